// File: doc/BRIEF.md
# Configurable Trigger Interrupt Controller

This block collects up to 32 interrupt sources into one interrupt line for a processor. Software configures it through a small word-addressed register port with separate read and write strobes. Each source can be set to detect a rising edge, a falling edge, a high level or a low level. Every detected event is held in a pending register until software acknowledges it. A second register masks the sources. Any pending source that is unmasked drives the output line. Software can program that line as a level or as a pulse, and can make it active high or active low. Software can also inject a pending event on any source through a force register, which is useful for driver tests.

Each source input passes through two synchroniser flops before trigger detection. A change on a source therefore shows up in the pending register at the third rising clock edge after the change. The output flop adds one further cycle. Read data is registered: a read strobe in one cycle returns its data in the next cycle. The register port is a plain control interface. It has no back-pressure, and every strobe is accepted in the cycle it is presented.

Top module: `irqc_top`

## Requirements
- R1: After reset the unmask register (0x00), pending register (0x04), output-style register (0x10) and output-polarity register (0x14) read 0. The trigger-kind register (0x08) and trigger-polarity register (0x0C) read all ones, which is rising edge on every source. With output polarity 0 the line is inverted, so irq_o is 1 after reset.
- R2: A read with rd_i high returns the addressed register on rdata_o at the next clock. Bit i of each register belongs to source i, and the output registers use bit 0. The force address 0x18 reads 0. Any other address, including an unaligned one, reads 0, and a write to it changes no register.
- R3: The pair {kind bit, polarity bit} selects the trigger of a source: 11 is rising edge, 10 is falling edge, 01 is active-high level and 00 is active-low level. A qualifying change on a source sets its pending bit at the third rising clock edge after the change. An edge in the opposite direction sets nothing.
- R4: An edge-triggered pending bit stays set until software writes 1 to it at 0x04. Writing 0 to a bit leaves it unchanged.
- R5: A level-triggered pending bit is sticky. A clear written while the level is still active has no effect. A clear written after the level has gone inactive clears the bit.
- R6: When a new trigger and a clear of the same bit meet in one clock, the trigger wins and the bit stays pending.
- R7: Writing 1 to a bit at 0x18 sets the matching pending bit at that write's clock edge, in any trigger mode.
- R8: An unmask bit of 0 keeps its source from driving the output. Changing the unmask register never clears a pending bit.
- R9: With output style 0 (level), the raw output is 1 one clock after any bit of (pending AND unmask) is 1, and 0 one clock after none is.
- R10: With output style 1 (pulse), the raw output is high for exactly one clock, one clock after a bit becomes newly set in (pending AND unmask). A bit that is already pending produces no further pulse.
- R11: irq_o equals the raw output when output polarity is 1 and its inverse when output polarity is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Interrupt source inputs, asynchronous to clk_i |
| addr_i | input | 8 | Byte address of the register access |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid the clock after rd_i |
| irq_o | output | 1 | Aggregated interrupt line |

## Verification
The hardest case to reach from the ports is the collision of R6, where a source edge and an acknowledge of the same bit must land on the same clock edge. The source edge passes through the synchroniser, and the acknowledge arrives through the register port. The bench first makes the bit pending with a force write. It then changes the source at a falling clock edge and presents the clear write two falling edges later, so that both meet at the third rising edge. A clear written one cycle later, with no edge present, serves as the control. Every trigger encoding is also swept on every source bit of a 4-source build. The same sequence of assert, clear, release and clear is applied to each, so that the edge and level rules are told apart.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;

  // Register offsets; software decodes these, so they are fixed.
  typedef enum logic [REG_AW-1:0] {
    OFS_UNMASK = 8'h00,
    OFS_PEND   = 8'h04,
    OFS_KIND   = 8'h08,
    OFS_TPOL   = 8'h0C,
    OFS_OSTYLE = 8'h10,
    OFS_OPOL   = 8'h14,
    OFS_FORCE  = 8'h18
  } reg_ofs_e;

  // {kind, polarity} trigger encoding.
  typedef enum logic [1:0] {
    TRIG_LVL_LOW  = 2'b00,
    TRIG_LVL_HIGH = 2'b01,
    TRIG_FALL     = 2'b10,
    TRIG_RISE     = 2'b11
  } trig_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[0] <= '0;
          else         stg_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_sync_i,
  input  logic [NSRC-1:0] kind_i,
  input  logic [NSRC-1:0] tpol_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] frc_i,
  output logic [NSRC-1:0] hit_o,
  output logic [NSRC-1:0] pend_o
);

  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] pend_q;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic lvl_act;
      logic edge_act;

      always_comb begin
        lvl_act  = tpol_i[i] ? src_sync_i[i] : ~src_sync_i[i];
        edge_act = tpol_i[i] ? (src_sync_i[i] & ~prev_q[i])
                             : (~src_sync_i[i] & prev_q[i]);
        hit_o[i] = kind_i[i] ? edge_act : lvl_act;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q[i] <= 1'b0;
          pend_q[i] <= 1'b0;
        end else begin
          prev_q[i] <= src_sync_i[i];
          // A new trigger or a force beats a clear in the same cycle.
          pend_q[i] <= hit_o[i] | frc_i[i] | (pend_q[i] & ~clr_i[i]);
        end
      end
    end
  endgenerate

  assign pend_o = pend_q;

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              rd_i,
  input  logic [NSRC-1:0]   pend_i,
  output logic [NSRC-1:0]   unmask_o,
  output logic [NSRC-1:0]   kind_o,
  output logic [NSRC-1:0]   tpol_o,
  output logic              ostyle_o,
  output logic              opol_o,
  output logic [NSRC-1:0]   clr_o,
  output logic [NSRC-1:0]   frc_o,
  output logic [REG_DW-1:0] rdata_o
);

  logic [NSRC-1:0]   unmask_q, kind_q, tpol_q;
  logic              ostyle_q, opol_q;
  logic [REG_DW-1:0] rdata_q;
  logic [REG_DW-1:0] rd_mux;

  function automatic logic [REG_DW-1:0] widen(input logic [NSRC-1:0] v);
    logic [REG_DW-1:0] r;
    r = '0;
    r[NSRC-1:0] = v;
    return r;
  endfunction

  // Acknowledge and force act only on the cycle of their write.
  always_comb begin
    clr_o = '0;
    frc_o = '0;
    if (wr_i && addr_i == OFS_PEND)  clr_o = wdata_i[NSRC-1:0];
    if (wr_i && addr_i == OFS_FORCE) frc_o = wdata_i[NSRC-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unmask_q <= '0;
      kind_q   <= '1;
      tpol_q   <= '1;
      ostyle_q <= 1'b0;
      opol_q   <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_UNMASK: unmask_q <= wdata_i[NSRC-1:0];
        OFS_KIND:   kind_q   <= wdata_i[NSRC-1:0];
        OFS_TPOL:   tpol_q   <= wdata_i[NSRC-1:0];
        OFS_OSTYLE: ostyle_q <= wdata_i[0];
        OFS_OPOL:   opol_q   <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      OFS_UNMASK: rd_mux = widen(unmask_q);
      OFS_PEND:   rd_mux = widen(pend_i);
      OFS_KIND:   rd_mux = widen(kind_q);
      OFS_TPOL:   rd_mux = widen(tpol_q);
      OFS_OSTYLE: rd_mux = {{(REG_DW-1){1'b0}}, ostyle_q};
      OFS_OPOL:   rd_mux = {{(REG_DW-1){1'b0}}, opol_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign unmask_o = unmask_q;
  assign kind_o   = kind_q;
  assign tpol_o   = tpol_q;
  assign ostyle_o = ostyle_q;
  assign opol_o   = opol_q;
  assign rdata_o  = rdata_q;

endmodule

// File: rtl/irqc_out.sv
module irqc_out #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] unmask_i,
  input  logic            ostyle_i,
  input  logic            opol_i,
  output logic            irq_o
);

  logic [NSRC-1:0] live;
  logic [NSRC-1:0] seen_q;
  logic            lvl_q;
  logic            pls_q;
  logic            raw;

  assign live = pend_i & unmask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      lvl_q  <= 1'b0;
      pls_q  <= 1'b0;
    end else begin
      seen_q <= live;
      lvl_q  <= |live;
      pls_q  <= |(live & ~seen_q);
    end
  end

  assign raw   = ostyle_i ? pls_q : lvl_q;
  assign irq_o = opol_i ? raw : ~raw;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              rd_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              irq_o
);

  logic [NSRC-1:0] src_sync;
  logic [NSRC-1:0] unmask, kind, tpol, clr, frc, hit, pend;
  logic            ostyle, opol;

  irqc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  irqc_regs #(.NSRC(NSRC)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rd_i    (rd_i),
    .pend_i  (pend),
    .unmask_o(unmask),
    .kind_o  (kind),
    .tpol_o  (tpol),
    .ostyle_o(ostyle),
    .opol_o  (opol),
    .clr_o   (clr),
    .frc_o   (frc),
    .rdata_o (rdata_o)
  );

  irqc_detect #(.NSRC(NSRC)) u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_sync_i(src_sync),
    .kind_i    (kind),
    .tpol_i    (tpol),
    .clr_i     (clr),
    .frc_i     (frc),
    .hit_o     (hit),
    .pend_o    (pend)
  );

  irqc_out #(.NSRC(NSRC)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend),
    .unmask_i(unmask),
    .ostyle_i(ostyle),
    .opol_i  (opol),
    .irq_o   (irq_o)
  );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NSRC = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [7:0]      addr_i,
  input logic            wr_i,
  input logic [31:0]     wdata_i,
  input logic            irq_o,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] unmask,
  input logic [NSRC-1:0] kind,
  input logic [NSRC-1:0] tpol,
  input logic [NSRC-1:0] hit,
  input logic            ostyle,
  input logic            opol
);

  logic known_addr;
  assign known_addr = (addr_i == 8'h00) || (addr_i == 8'h04) || (addr_i == 8'h08) ||
                      (addr_i == 8'h0C) || (addr_i == 8'h10) || (addr_i == 8'h14) ||
                      (addr_i == 8'h18);

  // R2
  undef_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !known_addr && hit == '0) |=>
      ($stable(unmask) && $stable(kind) && $stable(tpol) &&
       $stable(ostyle) && $stable(opol) && $stable(pend)));

  // R6
  trigger_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((pend & $past(hit)) == $past(hit)));

  // R7
  force_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 8'h18) |=>
      ((pend & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0])));

  // R8
  mask_keeps_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 8'h00 && hit == '0) |=> $stable(pend));

  // R9
  level_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ostyle && opol && !wr_i) |=> (irq_o == $past(|(pend & unmask))));

endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC)) u_irqc_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_i   (wr_i),
  .wdata_i(wdata_i),
  .irq_o  (irq_o),
  .pend   (pend),
  .unmask (unmask),
  .kind   (kind),
  .tpol   (tpol),
  .hit    (hit),
  .ostyle (ostyle),
  .opol   (opol)
);

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
  import irqc_pkg::*;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  irqc_top #(.NSRC(N)) i_irqc_top (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 irq_o", {31'b0, irq}, 32'h1);
    rd_reg(OFS_UNMASK, v); chk("R1 unmask", v, 32'h0);
    rd_reg(OFS_PEND, v);   chk("R1 pend", v, 32'h0);
    rd_reg(OFS_KIND, v);   chk("R1 kind", v, 32'hF);
    rd_reg(OFS_TPOL, v);   chk("R1 tpol", v, 32'hF);
    rd_reg(OFS_OSTYLE, v); chk("R1 ostyle", v, 32'h0);
    rd_reg(OFS_OPOL, v);   chk("R1 opol", v, 32'h0);

    // R2 readback, force and undefined addresses
    wr_reg(OFS_UNMASK, 32'hFFFF_FFFA);
    rd_reg(OFS_UNMASK, v); chk("R2 unmask readback", v, 32'hA);
    wr_reg(OFS_UNMASK, 32'h0);
    rd_reg(OFS_FORCE, v);  chk("R2 force reads zero", v, 32'h0);
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    wr_reg(8'h02, 32'hFFFF_FFFF);
    rd_reg(8'h1C, v);      chk("R2 undefined read", v, 32'h0);
    rd_reg(8'h02, v);      chk("R2 unaligned read", v, 32'h0);
    rd_reg(OFS_UNMASK, v); chk("R2 unmask untouched", v, 32'h0);
    rd_reg(OFS_KIND, v);   chk("R2 kind untouched", v, 32'hF);
    rd_reg(OFS_PEND, v);   chk("R2 pend untouched", v, 32'h0);
    rd_reg(OFS_OPOL, v);   chk("R2 opol untouched", v, 32'h0);

    // R3 R4 R5 sweep of every trigger on every source bit
    for (int b = 0; b < N; b++) begin
      for (int t = 0; t < 4; t++) begin
        src = {N{~t[0]}};
        idle(4);
        wr_reg(OFS_KIND, {32{t[1]}});
        wr_reg(OFS_TPOL, {32{t[0]}});
        idle(4);
        wr_reg(OFS_PEND, 32'hF);
        rd_reg(OFS_PEND, v); chk("R3 idle no trigger", v, 32'h0);
        src[b] = t[0];
        idle(4);
        rd_reg(OFS_PEND, v); chk("R3 trigger sets bit", v, 32'h1 << b);
        wr_reg(OFS_PEND, 32'h0);
        rd_reg(OFS_PEND, v); chk("R4 write zero keeps", v, 32'h1 << b);
        wr_reg(OFS_PEND, 32'h1 << b);
        rd_reg(OFS_PEND, v);
        chk(t[1] ? "R4 edge cleared" : "R5 level clear ignored", v, t[1] ? 32'h0 : (32'h1 << b));
        src[b] = ~t[0];
        idle(4);
        rd_reg(OFS_PEND, v);
        chk(t[1] ? "R3 opposite edge ignored" : "R5 level sticky", v, t[1] ? 32'h0 : (32'h1 << b));
        wr_reg(OFS_PEND, 32'h1 << b);
        rd_reg(OFS_PEND, v); chk("R5 clear after release", v, 32'h0);
      end
    end

    // R3 sync latency: set at third rising edge after the change
    src = '0;
    wr_reg(OFS_KIND, 32'hF);
    wr_reg(OFS_TPOL, 32'hF);
    idle(4);
    wr_reg(OFS_PEND, 32'hF);
    src[2] = 1'b1;            // changed at a falling edge
    @(negedge clk); @(negedge clk);
    rd = 1'b1; addr = OFS_PEND; // read sampled at third rising edge
    @(negedge clk); rd = 1'b0;
    chk("R3 latency not yet", rdata, 32'h0);
    rd_reg(OFS_PEND, v); chk("R3 latency set", v, 32'h4);
    wr_reg(OFS_PEND, 32'hF);

    // R7 force
    wr_reg(OFS_FORCE, 32'h9);
    rd_reg(OFS_PEND, v); chk("R7 force sets", v, 32'h9);
    wr_reg(OFS_PEND, 32'hF);
    rd_reg(OFS_PEND, v); chk("R7 force cleared", v, 32'h0);

    // R6 trigger and clear in the same clock
    src = '0;
    idle(4);
    wr_reg(OFS_FORCE, 32'h1);
    src[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr = 1'b1; addr = OFS_PEND; wdata = 32'h1;
    @(negedge clk); wr = 1'b0;
    rd_reg(OFS_PEND, v); chk("R6 trigger wins", v, 32'h1);
    wr_reg(OFS_PEND, 32'h1);
    rd_reg(OFS_PEND, v); chk("R6 control clear", v, 32'h0);

    // R9 level output, R8 masking
    wr_reg(OFS_OPOL, 32'h1);
    wr_reg(OFS_FORCE, 32'h1);
    idle(2);
    chk("R8 masked no irq", {31'b0, irq}, 32'h0);
    wr_reg(OFS_UNMASK, 32'h1);
    chk("R9 one cycle delay", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq asserted", {31'b0, irq}, 32'h1);
    wr_reg(OFS_UNMASK, 32'h0);
    chk("R9 drop delay", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 mask drops irq", {31'b0, irq}, 32'h0);
    rd_reg(OFS_PEND, v); chk("R8 mask keeps pend", v, 32'h1);

    // R11 polarity
    wr_reg(OFS_OPOL, 32'h0);
    chk("R11 inverted idle", {31'b0, irq}, 32'h1);
    wr_reg(OFS_UNMASK, 32'h1);
    @(negedge clk);
    chk("R11 inverted active", {31'b0, irq}, 32'h0);
    wr_reg(OFS_OPOL, 32'h1);
    chk("R11 true active", {31'b0, irq}, 32'h1);
    wr_reg(OFS_UNMASK, 32'h0);
    wr_reg(OFS_PEND, 32'hF);

    // R10 pulse output
    wr_reg(OFS_OSTYLE, 32'h1);
    wr_reg(OFS_UNMASK, 32'hF);
    idle(2);
    chk("R10 quiet", {31'b0, irq}, 32'h0);
    wr_reg(OFS_FORCE, 32'h2);
    chk("R10 pulse delay", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R10 pulse high", {31'b0, irq}, 32'h1);
    @(negedge clk); chk("R10 pulse one cycle", {31'b0, irq}, 32'h0);
    wr_reg(OFS_FORCE, 32'h2);
    @(negedge clk); chk("R10 no repeat pulse", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R10 no repeat pulse late", {31'b0, irq}, 32'h0);
    wr_reg(OFS_FORCE, 32'h4);
    @(negedge clk); chk("R10 second bit pulse", {31'b0, irq}, 32'h1);
    @(negedge clk); chk("R10 second pulse ends", {31'b0, irq}, 32'h0);

    finish_run();
  end

endmodule